// File: doc/BRIEF.md
# Dual-Bank Interrupt Register File

This block gathers forty level-sensitive interrupt sources into two banks, a low bank of thirty-two sources and a high bank of eight. Each source has three bits of state: one that mirrors the source's input level, one that enables it, and one that routes it. The route bit sends the source to either the fast interrupt line or the normal interrupt line. The block combines these bits into the two interrupt outputs. It also produces a wake request for a halted core. One control bit selects whether any pending source may wake the core or only enabled ones.

Software reaches the state through a simple synchronous register port. Writes take effect at the clock edge. Read data appears on the cycle after the read strobe. The block also stores forty priority entries, each holding a valid flag and a six-bit source number. The priority lookup that produces the "top candidate" word is a separate block. Its result enters on an input port, and this block returns that value at its own offset.

Top module: `intc_bank_regs`

## Requirements
- R1: A source's pending bit equals the source input as sampled at the previous rising clock edge; it is not sticky. The raw pending view returns it unmasked: offset 0x10 returns sources 0–31, and offset 0xAC returns sources 32–39 in bits 7:0.
- R2: `fiq_o` is high exactly when some source is pending, enabled, and has route bit 1. `irq_o` is high exactly when some source is pending, enabled, and has route bit 0.
- R3: The normal-line pending view returns pending AND enable AND NOT route, at 0x00 (low bank) and 0x9C (high bank). The fast-line pending view returns pending AND enable AND route, at 0x0C and 0xA8.
- R4: The enable registers (0x04 low, 0xA0 high) and route registers (0x08 low, 0xA4 high) read back what was written. High-bank registers keep only bits 7:0, and bits 31:8 read as zero.
- R5: Control register 0x14: a write stores bit 0 as the restrict flag. A read returns the flag in bit 0 and zero in bits 31:1.
- R6: `wake_o` is low while `halted` is low. While `halted` is high, `wake_o` is the OR over all sources of pending AND (enable OR NOT restrict).
- R7: Priority entry i sits at 0x1C+4i for i<32 and at 0xB0+4(i−32) for i≥32. A write stores only bit 31 and bits 5:0, and all other bits read as zero.
- R8: Writes to the pending views (0x00, 0x0C, 0x10, 0x9C, 0xA8, 0xAC) change no state. Unmapped or unaligned offsets read zero, and writes to them change no state.
- R9: After reset, the enable, route and pending bits and all priority entries are zero, the restrict flag is 1, and `bus_rdata` is zero.
- R10: A read of offset 0x18 returns the value on `top_prio_i`.
- R11: `bus_rdata` takes the addressed value at the rising edge where `bus_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 40 | Interrupt source levels, bit i is source i |
| halted | input | 1 | Core is halted; enables the wake output |
| top_prio_i | input | 32 | Result of the external priority lookup |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request to a halted core |

## Verification
A wrong enable or route bit shows up at `fiq_o` or `irq_o` one cycle after the affected source rises, so the bench walks a single active source through all forty positions under both route patterns. A priority entry written to the wrong slot, or a bank select that aliases the two banks, shows only on read-back. For that reason every priority entry is written with a distinct value before any entry is read. A wrong restrict flag stays invisible until the core is halted with a disabled source pending, and the wake test sets up exactly that case.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BANK_W = 32;

    localparam logic [ADDR_W-1:0] OFF_IRQV_LO  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_EN_LO    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ROUTE_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_FIQV_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_RAW_LO   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TOP      = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IRQV_HI  = 8'h9C;
    localparam logic [ADDR_W-1:0] OFF_EN_HI    = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_ROUTE_HI = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_FIQV_HI  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFF_RAW_HI   = 8'hAC;
    localparam logic [ADDR_W-1:0] PRIO_LO_BASE = 8'h1C;
    localparam logic [ADDR_W-1:0] PRIO_LO_LAST = 8'h98;
    localparam logic [ADDR_W-1:0] PRIO_HI_BASE = 8'hB0;
    localparam logic [ADDR_W-1:0] PRIO_HI_LAST = 8'hCC;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_IRQV, SEL_EN, SEL_ROUTE, SEL_FIQV,
        SEL_RAW, SEL_CTRL, SEL_TOP, SEL_PRIO
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic       hi;
        logic [5:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic       valid;
        logic [5:0] id;
    } prio_entry_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.hi  = 1'b0;
        d.idx = '0;
        case (a)
            OFF_IRQV_LO:  d.sel = SEL_IRQV;
            OFF_EN_LO:    d.sel = SEL_EN;
            OFF_ROUTE_LO: d.sel = SEL_ROUTE;
            OFF_FIQV_LO:  d.sel = SEL_FIQV;
            OFF_RAW_LO:   d.sel = SEL_RAW;
            OFF_CTRL:     d.sel = SEL_CTRL;
            OFF_TOP:      d.sel = SEL_TOP;
            OFF_IRQV_HI:  begin d.sel = SEL_IRQV;  d.hi = 1'b1; end
            OFF_EN_HI:    begin d.sel = SEL_EN;    d.hi = 1'b1; end
            OFF_ROUTE_HI: begin d.sel = SEL_ROUTE; d.hi = 1'b1; end
            OFF_FIQV_HI:  begin d.sel = SEL_FIQV;  d.hi = 1'b1; end
            OFF_RAW_HI:   begin d.sel = SEL_RAW;   d.hi = 1'b1; end
            default: begin
                if (a[1:0] == 2'b00 && a >= PRIO_LO_BASE && a <= PRIO_LO_LAST) begin
                    d.sel = SEL_PRIO;
                    d.idx = 6'((a - PRIO_LO_BASE) >> 2);
                end else if (a[1:0] == 2'b00 && a >= PRIO_HI_BASE && a <= PRIO_HI_LAST) begin
                    d.sel = SEL_PRIO;
                    d.idx = 6'(BANK_W + int'((a - PRIO_HI_BASE) >> 2));
                end
            end
        endcase
        return d;
    endfunction

    function automatic prio_entry_t prio_from_word(input logic [DATA_W-1:0] w);
        prio_entry_t e;
        e.valid = w[31];
        e.id    = w[5:0];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] prio_to_word(input prio_entry_t e);
        return {e.valid, 25'd0, e.id};
    endfunction

endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic         we_en,
    input  logic         we_route,
    input  logic [W-1:0] wdata,
    input  logic         wake_any,
    output logic [W-1:0] pend,
    output logic [W-1:0] en,
    output logic [W-1:0] route,
    output logic         fiq_hit,
    output logic         irq_hit,
    output logic         wake_hit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            en    <= '0;
            route <= '0;
        end else begin
            pend <= level;
            if (we_en)    en    <= wdata;
            if (we_route) route <= wdata;
        end
    end

    logic [W-1:0] live;
    assign live     = pend & en;
    assign fiq_hit  = |(live & route);
    assign irq_hit  = |(live & ~route);
    assign wake_hit = |(pend & (en | {W{wake_any}}));

endmodule

// File: rtl/intc_prio_store.sv
module intc_prio_store
    import intc_pkg::*;
#(
    parameter int N = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [5:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    prio_entry_t entries [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entries[i] <= '0;
            else if (we && idx == 6'(i))
                entries[i] <= prio_from_word(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (idx == 6'(i)) rdata = prio_to_word(entries[i]);
    end

endmodule

// File: rtl/intc_bank_regs.sv
module intc_bank_regs
    import intc_pkg::*;
#(
    parameter int NSRC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_level,
    input  logic              halted,
    input  logic [DATA_W-1:0] top_prio_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fiq_o,
    output logic              irq_o,
    output logic              wake_o
);

    localparam int LO_W    = BANK_W;
    localparam int HI_W    = NSRC - BANK_W;
    localparam int N_BANKS = 2;

    reg_dec_t dec;
    logic     idx_ok;
    assign dec    = decode_addr(bus_addr);
    assign idx_ok = int'(dec.idx) < NSRC;

    logic restrict_q;
    logic [N_BANKS-1:0][DATA_W-1:0] bk_pend, bk_en, bk_route;
    logic [N_BANKS-1:0] bk_fiq, bk_irq, bk_wake;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam int BW = (b == 0) ? LO_W : HI_W;
        logic sel_bank;
        assign sel_bank = bus_wr && (dec.hi == 1'(b));

        intc_src_bank #(.W(BW)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .level    (src_level[b*BANK_W +: BW]),
            .we_en    (sel_bank && dec.sel == SEL_EN),
            .we_route (sel_bank && dec.sel == SEL_ROUTE),
            .wdata    (bus_wdata[BW-1:0]),
            .wake_any (~restrict_q),
            .pend     (bk_pend[b][BW-1:0]),
            .en       (bk_en[b][BW-1:0]),
            .route    (bk_route[b][BW-1:0]),
            .fiq_hit  (bk_fiq[b]),
            .irq_hit  (bk_irq[b]),
            .wake_hit (bk_wake[b])
        );

        if (BW < DATA_W) begin : g_pad
            assign bk_pend[b][DATA_W-1:BW]  = '0;
            assign bk_en[b][DATA_W-1:BW]    = '0;
            assign bk_route[b][DATA_W-1:BW] = '0;
        end
    end

    logic [DATA_W-1:0] prio_rdata;

    intc_prio_store #(.N(NSRC)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_wr && dec.sel == SEL_PRIO && idx_ok),
        .idx   (dec.idx),
        .wdata (bus_wdata),
        .rdata (prio_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            restrict_q <= 1'b1;
        else if (bus_wr && dec.sel == SEL_CTRL)
            restrict_q <= bus_wdata[0];
    end

    assign fiq_o  = |bk_fiq;
    assign irq_o  = |bk_irq;
    assign wake_o = halted && (|bk_wake);

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        unique case (dec.sel)
            SEL_IRQV:  rd_mux = bk_pend[dec.hi] & bk_en[dec.hi] & ~bk_route[dec.hi];
            SEL_FIQV:  rd_mux = bk_pend[dec.hi] & bk_en[dec.hi] & bk_route[dec.hi];
            SEL_RAW:   rd_mux = bk_pend[dec.hi];
            SEL_EN:    rd_mux = bk_en[dec.hi];
            SEL_ROUTE: rd_mux = bk_route[dec.hi];
            SEL_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, restrict_q};
            SEL_TOP:   rd_mux = top_prio_i;
            SEL_PRIO:  rd_mux = idx_ok ? prio_rdata : '0;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/intc_bank_regs_chk.sv
module intc_bank_regs_chk
    import intc_pkg::*;
#(
    parameter int NSRC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_level,
    input logic              halted,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              fiq_o,
    input logic              irq_o,
    input logic              wake_o
);

    // R1
    quiet_sources_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(src_level) == '0) |-> (!fiq_o && !irq_o && !wake_o));

    // R6
    wake_needs_halt_chk: assert property (@(posedge clk) disable iff (rst)
        !halted |-> !wake_o);

    // R5
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_CTRL) |=> (bus_rdata[31:1] == '0));

    // R4
    hi_bank_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr >= OFF_IRQV_HI && bus_addr <= OFF_RAW_HI)
        |=> (bus_rdata[31:8] == '0));

    // R7
    prio_field_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr >= PRIO_LO_BASE && bus_addr <= PRIO_LO_LAST)
        |=> (bus_rdata[30:6] == '0));

    // R8
    unaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));

endmodule

bind intc_bank_regs intc_bank_regs_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_level (src_level),
    .halted    (halted),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .fiq_o     (fiq_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/intc_bank_regs_bench.sv
module intc_bank_regs_bench;

    localparam int NSRC = 40;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_level = '0;
    logic            halted = 1'b0;
    logic [31:0]     top_prio_i = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            fiq_o, irq_o, wake_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intc_bank_regs #(.NSRC(NSRC)) u_intc_bank_regs (
        .clk(clk), .rst(rst), .src_level(src_level), .halted(halted),
        .top_prio_i(top_prio_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_o(fiq_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src_level = v;
        @(negedge clk);
    endtask

    function automatic logic [31:0] lo(input logic [NSRC-1:0] v);
        return v[31:0];
    endfunction

    function automatic logic [31:0] hi(input logic [NSRC-1:0] v);
        return {24'd0, v[NSRC-1:32]};
    endfunction

    logic [NSRC-1:0] en_m, route_m;
    logic [31:0] r;

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 rdata", bus_rdata, 32'h0);
        check("R9 outputs", {29'd0, fiq_o, irq_o, wake_o}, 32'h0);
        rd(8'h04, r); check("R9 en lo", r, 32'h0);
        rd(8'hA4, r); check("R9 route hi", r, 32'h0);
        rd(8'h14, r); check("R9 R5 ctrl", r, 32'h1);
        rd(8'h1C, r); check("R9 prio0", r, 32'h0);

        // R4 enable/route write and read-back, high bank truncation
        wr(8'h04, 32'hDEAD_BEEF); rd(8'h04, r); check("R4 en lo", r, 32'hDEAD_BEEF);
        wr(8'hA0, 32'h1234_56C3); rd(8'hA0, r); check("R4 en hi", r, 32'h0000_00C3);
        wr(8'h08, 32'h0F0F_0F0F); rd(8'h08, r); check("R4 route lo", r, 32'h0F0F_0F0F);
        wr(8'hA4, 32'hFFFF_FF5A); rd(8'hA4, r); check("R4 route hi", r, 32'h0000_005A);

        // R2 R3 sweep: one active source at every position, two route patterns
        for (int pat = 0; pat < 2; pat++) begin
            en_m    = '1;
            route_m = (pat == 0) ? {NSRC/2{2'b10}} : {NSRC/2{2'b01}};
            wr(8'h04, lo(en_m));    wr(8'hA0, hi(en_m));
            wr(8'h08, lo(route_m)); wr(8'hA4, hi(route_m));
            for (int i = 0; i < NSRC; i++) begin
                logic [NSRC-1:0] s;
                s = '0; s[i] = 1'b1;
                set_src(s);
                check("R2 fiq", {31'd0, fiq_o}, {31'd0, route_m[i]});
                check("R2 irq", {31'd0, irq_o}, {31'd0, ~route_m[i]});
                rd((i < 32) ? 8'h0C : 8'hA8, r);
                check("R3 fiq view", r, (i < 32) ? lo(s & en_m & route_m) : hi(s & en_m & route_m));
                rd((i < 32) ? 8'h00 : 8'h9C, r);
                check("R3 irq view", r, (i < 32) ? lo(s & en_m & ~route_m) : hi(s & en_m & ~route_m));
            end
        end

        // R1 raw view unmasked, R2 disabled sources drive nothing
        wr(8'h04, 32'h0); wr(8'hA0, 32'h0);
        set_src(40'hA5_1234_5678);
        check("R2 masked fiq/irq", {30'd0, fiq_o, irq_o}, 32'h0);
        rd(8'h10, r); check("R1 raw lo", r, 32'h1234_5678);
        rd(8'hAC, r); check("R1 raw hi", r, 32'h0000_00A5);
        rd(8'h00, r); check("R3 masked irq view", r, 32'h0);
        // R1 not sticky: level drops, pending clears
        set_src('0);
        rd(8'h10, r); check("R1 raw clears", r, 32'h0);
        rd(8'hAC, r); check("R1 raw hi clears", r, 32'h0);
        check("R1 outputs idle", {30'd0, fiq_o, irq_o}, 32'h0);

        // R6 wake control with R5 flag
        set_src(40'h00_0000_0020);
        check("R6 not halted", {31'd0, wake_o}, 32'h0);
        halted = 1'b1;
        #1 check("R6 restricted, disabled", {31'd0, wake_o}, 32'h0);
        wr(8'h14, 32'hFFFF_FFFE);
        rd(8'h14, r); check("R5 ctrl 0", r, 32'h0);
        check("R6 any source wakes", {31'd0, wake_o}, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h14, r); check("R5 ctrl 1", r, 32'h1);
        check("R6 restricted again", {31'd0, wake_o}, 32'h0);
        wr(8'h04, 32'h0000_0020);
        check("R6 enabled wakes", {31'd0, wake_o}, 32'h1);
        set_src(40'h80_0000_0000); wr(8'h04, 32'h0);
        check("R6 hi disabled", {31'd0, wake_o}, 32'h0);
        wr(8'hA0, 32'h80);
        check("R6 hi enabled", {31'd0, wake_o}, 32'h1);
        halted = 1'b0;
        #1 check("R6 released", {31'd0, wake_o}, 32'h0);

        // R8 writes to views and unmapped offsets change nothing
        wr(8'hAC, 32'hFFFF_FFFF); wr(8'hA8, 32'hFFFF_FFFF); wr(8'h9C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'hD0, 32'hFFFF_FFFF); wr(8'h05, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'hAC, r); check("R8 raw hi", r, 32'h80);
        rd(8'h10, r); check("R8 raw lo", r, 32'h0);
        rd(8'h04, r); check("R8 en lo kept", r, 32'h0);
        rd(8'hA0, r); check("R8 en hi kept", r, 32'h80);
        rd(8'h08, r); check("R8 route lo kept", r, 32'h5555_5555);
        rd(8'h14, r); check("R8 ctrl kept", r, 32'h1);
        rd(8'hD0, r); check("R8 unmapped", r, 32'h0);
        rd(8'h05, r); check("R8 unaligned", r, 32'h0);
        rd(8'h1E, r); check("R8 unaligned prio", r, 32'h0);

        // R10 passthrough
        top_prio_i = 32'h8015_0027;
        rd(8'h18, r); check("R10 top", r, 32'h8015_0027);

        // R7 priority entries: write all, then read all
        for (int i = 0; i < NSRC; i++) begin
            logic [7:0] a;
            a = (i < 32) ? 8'(8'h1C + 4*i) : 8'(8'hB0 + 4*(i-32));
            wr(a, ((i % 2) ? 32'h8000_0000 : 32'h0) | 32'h5A5A_5A00 | 32'(i + 3));
        end
        for (int i = 0; i < NSRC; i++) begin
            logic [7:0] a;
            a = (i < 32) ? 8'(8'h1C + 4*i) : 8'(8'hB0 + 4*(i-32));
            rd(a, r);
            check("R7 prio", r, (((i % 2) ? 32'h8000_0000 : 32'h0) | 32'h5A5A_5A00 | 32'(i + 3)) & 32'h8000_003F);
        end

        // R11 read data holds without a read strobe
        rd(8'h1C, r);
        bus_addr = 8'h18;
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 32'h0000_0003);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule